// File: doc/BRIEF.md
# Phase-Aligned Receive Path Bring-Up Controller

This block brings up a source-synchronous deserializer receive path whose sampling phase is chosen by a dynamic phase-alignment circuit. It has three reset outputs: one for the clock-generating PLL, one for the phase-alignment circuit and one for the receive FIFO. It orders them around two lock indications that come from other clock domains. When the sequence completes, it raises `ready`. Downstream word-boundary (bit-slip) alignment may start only after that point.

After power-up, or after a `restart_req` pulse, both the PLL reset and the phase-alignment reset go high. The PLL reset stays high for a minimum time, which is given in picoseconds and converted into a whole number of controller clock cycles. After the PLL reset is released, the controller waits until the PLL lock has been high for a run of consecutive cycles. Only then does it release the phase-alignment reset, so that alignment cannot settle on a poor tap while the clock is still moving. The controller then waits for phase-alignment lock, with the link partner sending transitions. It flushes the FIFO with a short reset pulse and enters normal operation.

The controller restarts the sequence in three cases: loss of PLL lock after the PLL lock wait, a restart request, or expiry of one of the optional wait timeouts. A timeout also sets a sticky error flag.

Top module: `rx_align_bringup`

## Requirements
- R1: While `rst_n` is low, and from then until the first state change, `pll_rst` and `align_rst` are 1, while `fifo_rst`, `ready` and `timeout_err` are 0.
- R2: `pll_rst` stays high for exactly HOLD clock cycles on each entry to the PLL reset phase. HOLD is ceil(PLL_RST_MIN_PS / CLK_PERIOD_PS), with a minimum of 1, which gives 2 at a 5000 ps clock with a 10000 ps minimum. `align_rst` stays high during this phase.
- R3: Each lock input passes through two synchronizing flops before the state machine uses it. A lock input that rises and then stays high can therefore release `align_rst` no sooner than STABLE_CYC+2 clock edges after the change.
- R4: `align_rst` falls only after the synchronized PLL lock has been sampled high for STABLE_CYC consecutive cycles after `pll_rst` falls. A low sample restarts the count.
- R5: Once the synchronized phase-alignment lock is high, and the PLL lock is still held, `fifo_rst` pulses high for exactly FIFO_RST_CYC cycles.
- R6: `ready` rises in the same cycle that `fifo_rst` falls. It is never high together with any of the three resets.
- R7: A low synchronized PLL lock during the alignment wait, the FIFO flush or normal operation returns the controller to the PLL reset phase on the next edge, and `ready` drops.
- R8: `restart_req` sampled high in any state puts the controller in the PLL reset phase on the next edge, with `pll_rst` and `align_rst` high and `ready` low.
- R9: If PLL_LOCK_TO_CYC is not 0 and the stable-lock condition is not met within PLL_LOCK_TO_CYC cycles of `pll_rst` falling, `timeout_err` is set and the PLL reset phase is re-entered.
- R10: If ALIGN_LOCK_TO_CYC is not 0 and phase-alignment lock has not been seen within ALIGN_LOCK_TO_CYC cycles of `align_rst` falling, `timeout_err` is set and the PLL reset phase is re-entered.
- R11: `timeout_err` stays set through later restarts and successful bring-ups. Only `rst_n` clears it.
- R12: A drop of the phase-alignment lock while `ready` is high has no effect. `ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart_req | input | 1 | Synchronous request to rerun the whole sequence |
| pll_lock_in | input | 1 | PLL lock indication, asynchronous |
| align_lock_in | input | 1 | Phase-alignment lock indication, asynchronous |
| pll_rst | output | 1 | Reset to the PLL, active high |
| align_rst | output | 1 | Reset to the phase-alignment circuit, active high |
| fifo_rst | output | 1 | Reset to the receive FIFO, active high |
| ready | output | 1 | Receive path may capture data, and bit-slip may start |
| timeout_err | output | 1 | Sticky flag: a lock wait timed out |

## Verification
The assertions assume that `restart_req` is synchronous to `clk`. They also assume that the two lock inputs, although asynchronous, are held for whole clock periods, so that the synchronized copies follow them cleanly. The stimulus changes every input only at falling clock edges. It toggles the lock inputs with a bias: a lock that is low recovers quickly, and a lock that is high drops rarely, so that the random run reaches normal operation often and still passes through every wait and loss path. Restart requests are single-cycle pulses at random times.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  typedef enum logic [2:0] {
    ST_PLL_RST    = 3'd0,
    ST_PLL_WAIT   = 3'd1,
    ST_ALIGN_WAIT = 3'd2,
    ST_FIFO_RST   = 3'd3,
    ST_RUN        = 3'd4
  } bringup_st_e;

  // Whole cycles needed to cover a minimum time, never less than one.
  function automatic int unsigned cycles_for_ps(input int unsigned min_ps,
                                                input int unsigned period_ps);
    int unsigned c;
    c = (min_ps + period_ps - 1) / period_ps;
    return (c == 0) ? 1 : c;
  endfunction

  // Counter width able to hold the values 0 .. n-1.
  function automatic int unsigned width_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rxb_sync.sv
module rxb_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= '0;
        end else begin
          if (g == 0) stage_q[g] <= d_i;
          else        stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/rxb_run_counter.sv
module rxb_run_counter #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic done_o
);

  localparam int unsigned W = rxb_pkg::width_for(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign done_o = inc_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_i && !done_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/rxb_timeout.sv
module rxb_timeout #(
  parameter int unsigned LIMIT = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic expired_o
);

  generate
    if (LIMIT == 0) begin : g_off
      logic unused_inputs;
      assign unused_inputs = clk ^ rst_n ^ clr_i;
      assign expired_o     = 1'b0;
    end else begin : g_on
      rxb_run_counter #(.LIMIT(LIMIT)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_i),
        .inc_i (1'b1),
        .done_o(expired_o)
      );
    end
  endgenerate

endmodule

// File: rtl/rx_align_bringup.sv
module rx_align_bringup #(
  parameter int unsigned CLK_PERIOD_PS     = 5000,
  parameter int unsigned PLL_RST_MIN_PS    = 10000,
  parameter int unsigned STABLE_CYC        = 16,
  parameter int unsigned FIFO_RST_CYC      = 1,
  parameter int unsigned PLL_LOCK_TO_CYC   = 4096,
  parameter int unsigned ALIGN_LOCK_TO_CYC = 8192,
  parameter int unsigned SYNC_STAGES       = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_req,
  input  logic pll_lock_in,
  input  logic align_lock_in,
  output logic pll_rst,
  output logic align_rst,
  output logic fifo_rst,
  output logic ready,
  output logic timeout_err
);

  import rxb_pkg::*;

  localparam int unsigned HOLD_CYC = cycles_for_ps(PLL_RST_MIN_PS, CLK_PERIOD_PS);

  bringup_st_e st_q, st_d;

  logic [1:0] lock_raw, lock_s;
  logic pll_ok, align_ok;

  // Named internal events
  logic hold_done;
  logic lock_stable_hit;
  logic fifo_done;
  logic pll_to_hit;
  logic align_to_hit;
  logic lock_lost;
  logic timeout_hit;

  assign lock_raw = {align_lock_in, pll_lock_in};

  rxb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (lock_raw),
    .q_o  (lock_s)
  );

  assign pll_ok   = lock_s[0];
  assign align_ok = lock_s[1];

  rxb_run_counter #(.LIMIT(HOLD_CYC)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i ((st_q != ST_PLL_RST) || restart_req),
    .inc_i (st_q == ST_PLL_RST),
    .done_o(hold_done)
  );

  rxb_run_counter #(.LIMIT(STABLE_CYC)) u_stable (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i ((st_q != ST_PLL_WAIT) || !pll_ok),
    .inc_i ((st_q == ST_PLL_WAIT) && pll_ok),
    .done_o(lock_stable_hit)
  );

  rxb_run_counter #(.LIMIT(FIFO_RST_CYC)) u_flush (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (st_q != ST_FIFO_RST),
    .inc_i (st_q == ST_FIFO_RST),
    .done_o(fifo_done)
  );

  rxb_timeout #(.LIMIT(PLL_LOCK_TO_CYC)) u_pll_to (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (st_q != ST_PLL_WAIT),
    .expired_o(pll_to_hit)
  );

  rxb_timeout #(.LIMIT(ALIGN_LOCK_TO_CYC)) u_align_to (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (st_q != ST_ALIGN_WAIT),
    .expired_o(align_to_hit)
  );

  assign lock_lost = !pll_ok &&
                     ((st_q == ST_ALIGN_WAIT) || (st_q == ST_FIFO_RST) || (st_q == ST_RUN));

  always_comb begin
    st_d        = st_q;
    timeout_hit = 1'b0;
    unique case (st_q)
      ST_PLL_RST: begin
        if (hold_done) st_d = ST_PLL_WAIT;
      end
      ST_PLL_WAIT: begin
        if (lock_stable_hit) begin
          st_d = ST_ALIGN_WAIT;
        end else if (pll_to_hit) begin
          st_d        = ST_PLL_RST;
          timeout_hit = 1'b1;
        end
      end
      ST_ALIGN_WAIT: begin
        if (lock_lost) begin
          st_d = ST_PLL_RST;
        end else if (align_ok) begin
          st_d = ST_FIFO_RST;
        end else if (align_to_hit) begin
          st_d        = ST_PLL_RST;
          timeout_hit = 1'b1;
        end
      end
      ST_FIFO_RST: begin
        if (lock_lost)      st_d = ST_PLL_RST;
        else if (fifo_done) st_d = ST_RUN;
      end
      ST_RUN: begin
        if (lock_lost) st_d = ST_PLL_RST;
      end
      default: st_d = ST_PLL_RST;
    endcase
    if (restart_req) begin
      st_d        = ST_PLL_RST;
      timeout_hit = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_PLL_RST;
      pll_rst     <= 1'b1;
      align_rst   <= 1'b1;
      fifo_rst    <= 1'b0;
      ready       <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      st_q        <= st_d;
      pll_rst     <= (st_d == ST_PLL_RST);
      align_rst   <= (st_d == ST_PLL_RST) || (st_d == ST_PLL_WAIT);
      fifo_rst    <= (st_d == ST_FIFO_RST);
      ready       <= (st_d == ST_RUN);
      timeout_err <= timeout_err || timeout_hit;
    end
  end

endmodule

// File: rtl/rxb_chk.sv
module rxb_chk #(
  parameter int unsigned HOLD_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic restart_req,
  input logic pll_ok,
  input logic lock_stable_hit,
  input logic pll_rst,
  input logic align_rst,
  input logic fifo_rst,
  input logic ready,
  input logic timeout_err
);

  localparam int unsigned CW = rxb_pkg::width_for(HOLD_CYC + 2);

  logic [CW-1:0] high_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            high_run_q <= '0;
    else if (!pll_rst)                     high_run_q <= '0;
    else if (high_run_q != {CW{1'b1}})     high_run_q <= high_run_q + 1'b1;
  end

  // R1
  rst_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_rst |-> align_rst);

  // R2
  hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_rst) |-> (high_run_q >= CW'(HOLD_CYC)));

  // R4
  align_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (align_rst && !pll_rst && !restart_req && lock_stable_hit) |=> !align_rst);

  // R5
  fifo_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_rst) |-> (!pll_rst && !align_rst && !ready));

  // R6
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!pll_rst && !align_rst && !fifo_rst));

  // R7
  lock_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !pll_ok) |=> (!ready && pll_rst));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> (pll_rst && align_rst && !ready && !fifo_rst));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err);

endmodule

bind rx_align_bringup rxb_chk #(.HOLD_CYC(HOLD_CYC)) u_rxb_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .restart_req    (restart_req),
  .pll_ok         (pll_ok),
  .lock_stable_hit(lock_stable_hit),
  .pll_rst        (pll_rst),
  .align_rst      (align_rst),
  .fifo_rst       (fifo_rst),
  .ready          (ready),
  .timeout_err    (timeout_err)
);

// File: tb/tb_rx_align_bringup.sv
`timescale 1ns/1ps
module tb_rx_align_bringup;

  localparam int unsigned PER_PS   = 5000;
  localparam int unsigned MIN_PS   = 10000;
  localparam int unsigned STABLE   = 4;
  localparam int unsigned FIFO_CYC = 1;
  localparam int unsigned PLL_TO   = 40;
  localparam int unsigned ALIGN_TO = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart_req = 1'b0;
  logic pll_in = 1'b0;
  logic align_in = 1'b0;
  logic pll_rst, align_rst, fifo_rst, ready, timeout_err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit cmp_en = 1'b0;

  always #2.5 clk = ~clk;

  rx_align_bringup #(
    .CLK_PERIOD_PS    (PER_PS),
    .PLL_RST_MIN_PS   (MIN_PS),
    .STABLE_CYC       (STABLE),
    .FIFO_RST_CYC     (FIFO_CYC),
    .PLL_LOCK_TO_CYC  (PLL_TO),
    .ALIGN_LOCK_TO_CYC(ALIGN_TO),
    .SYNC_STAGES      (2)
  ) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart_req  (restart_req),
    .pll_lock_in  (pll_in),
    .align_lock_in(align_in),
    .pll_rst      (pll_rst),
    .align_rst    (align_rst),
    .fifo_rst     (fifo_rst),
    .ready        (ready),
    .timeout_err  (timeout_err)
  );

  function automatic int hold_expect(int unsigned min_ps, int unsigned per_ps);
    int n;
    n = 0;
    while (n * per_ps < min_ps) n++;
    return (n < 1) ? 1 : n;
  endfunction

  localparam int HOLD = hold_expect(MIN_PS, PER_PS);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference model, restating the requirements phase by phase:
  // 0 PLL reset, 1 PLL lock wait, 2 align wait, 3 FIFO flush, 4 running
  int m_ph, m_tin, m_run;
  bit m_err, p1, p2, a1, a2;

  always @(posedge clk or negedge rst_n) begin
    int nph, nrun;
    bit e;
    if (!rst_n) begin
      m_ph = 0; m_tin = 0; m_run = 0; m_err = 0;
      p1 = 0; p2 = 0; a1 = 0; a2 = 0;
    end else begin
      nph = m_ph; e = 0; nrun = 0;
      case (m_ph)
        0: if (m_tin + 1 >= HOLD) nph = 1;
        1: begin
          nrun = p2 ? m_run + 1 : 0;
          if (nrun >= STABLE) nph = 2;
          else if (PLL_TO != 0 && m_tin + 1 >= PLL_TO) begin nph = 0; e = 1; end
        end
        2: begin
          if (!p2) nph = 0;
          else if (a2) nph = 3;
          else if (ALIGN_TO != 0 && m_tin + 1 >= ALIGN_TO) begin nph = 0; e = 1; end
        end
        3: begin
          if (!p2) nph = 0;
          else if (m_tin + 1 >= FIFO_CYC) nph = 4;
        end
        default: if (!p2) nph = 0;
      endcase
      if (restart_req) begin nph = 0; e = 0; end
      if (nph != m_ph || restart_req) begin m_tin = 0; m_run = 0; end
      else begin m_tin = m_tin + 1; m_run = nrun; end
      m_ph = nph;
      m_err = m_err | e;
      p2 = p1; p1 = pll_in;
      a2 = a1; a1 = align_in;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      check(pll_rst == (m_ph == 0), "R2", "pll_rst vs model", pll_rst, m_ph == 0);
      check(align_rst == (m_ph <= 1), "R4", "align_rst vs model", align_rst, m_ph <= 1);
      check(fifo_rst == (m_ph == 3), "R5", "fifo_rst vs model", fifo_rst, m_ph == 3);
      check(ready == (m_ph == 4), "R6", "ready vs model", ready, m_ph == 4);
      check(timeout_err == m_err, "R11", "timeout_err vs model", timeout_err, m_err);
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; restart_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_low_pll_rst();
    for (int i = 0; i < 200 && pll_rst; i++) @(negedge clk);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 300 && !ready; i++) @(negedge clk);
  endtask

  initial begin
    int n;
    void'($urandom(32'h00C0FFEE));
    pll_in = 0; align_in = 0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R1: outputs while reset is held
    check(pll_rst && align_rst && !fifo_rst && !ready && !timeout_err, "R1",
          "reset outputs {pll,align,fifo,ready,err}",
          {pll_rst, align_rst, fifo_rst, ready, timeout_err}, 5'b11000);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    // R2: PLL reset length after reset release
    n = 0;
    do begin @(negedge clk); n++; end while (pll_rst && n < 50);
    check(n == HOLD, "R2", "pll_rst high cycles", n, HOLD);
    check(align_rst == 1'b1, "R1", "align_rst held after pll_rst release", align_rst, 1);
    // R3/R4: lock rise to align release takes STABLE+2 edges
    pll_in = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (align_rst && n < 100);
    check(n == STABLE + 2, "R3", "edges from lock rise to align release", n, STABLE + 2);
    // R5/R6
    align_in = 1'b1;
    for (int i = 0; i < 20 && !fifo_rst; i++) @(negedge clk);
    n = 0;
    while (fifo_rst && n < 20) begin @(negedge clk); n++; end
    check(n == FIFO_CYC, "R5", "fifo_rst pulse width", n, FIFO_CYC);
    check(ready == 1'b1, "R6", "ready after flush", ready, 1);
    // R12: align lock drop ignored while running
    align_in = 1'b0;
    repeat (10) @(negedge clk);
    check(ready == 1'b1, "R12", "ready after align lock drop", ready, 1);
    align_in = 1'b1;
    // R7: PLL lock loss while running
    pll_in = 1'b0;
    repeat (4) @(negedge clk);
    check(!ready && pll_rst, "R7", "{ready,pll_rst} after lock loss", {ready, pll_rst}, 2'b01);
    // R4: glitch during the stable window restarts the count
    wait_low_pll_rst();
    pll_in = 1'b1;
    repeat (STABLE) @(negedge clk);
    pll_in = 1'b0;
    @(negedge clk);
    pll_in = 1'b1;
    repeat (4) @(negedge clk);
    check(align_rst == 1'b1, "R4", "align_rst after lock glitch", align_rst, 1);
    wait_ready();
    check(ready == 1'b1, "R6", "ready after glitch recovery", ready, 1);
    // R8: restart from running
    restart_req = 1'b1;
    @(negedge clk);
    restart_req = 1'b0;
    check(pll_rst && align_rst && !ready, "R8", "{pll,align,ready} after restart",
          {pll_rst, align_rst, ready}, 3'b110);
    wait_ready();
    // R9: PLL lock never arrives
    pll_in = 0; align_in = 0;
    do_reset();
    repeat (HOLD + PLL_TO - 2) @(negedge clk);
    check(timeout_err == 1'b0, "R9", "err before PLL timeout", timeout_err, 0);
    repeat (4) @(negedge clk);
    check(timeout_err == 1'b1, "R9", "err after PLL timeout", timeout_err, 1);
    // R11: error survives a clean bring-up
    pll_in = 1; align_in = 1;
    wait_ready();
    check(ready && timeout_err, "R11", "{ready,err} after recovery", {ready, timeout_err}, 2'b11);
    // R10: align lock never arrives
    align_in = 0;
    do_reset();
    check(timeout_err == 1'b0, "R11", "err cleared by rst_n", timeout_err, 0);
    repeat (HOLD + STABLE + 2 + ALIGN_TO + 4) @(negedge clk);
    check(timeout_err == 1'b1, "R10", "err after align timeout", timeout_err, 1);
    // Random phase
    do_reset();
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      restart_req = ($urandom % 400) == 0;
      if (pll_in) begin if ($urandom % 300 == 0) pll_in = 0; end
      else if ($urandom % 8 == 0) pll_in = 1;
      if (align_in) begin if ($urandom % 150 == 0) align_in = 0; end
      else if ($urandom % 12 == 0) align_in = 1;
    end
    restart_req = 0;
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule